// File: doc/BRIEF.md
# Filtered Edge Timestamping Unit

The block watches four asynchronous digital inputs and reports every level change on them as a 64-bit event word. Each input is first brought into the clock domain by a two-stage synchroniser. It then passes through a glitch filter that accepts a new level only after the level has been seen for four consecutive clock cycles. At 125 MHz this means pulses shorter than 32 ns are dropped.

Each accepted level change, rising or falling, is stamped with the value of a free-running 56-bit counter. It is packed with the channel number and the polarity. The word is then offered to a downstream FIFO over a valid/ready interface.

Every channel owns one pending slot. When several channels change in the same cycle, their words leave one per transfer, lowest channel first, and all of them carry the same stamp. An event that finds its channel's slot still occupied is dropped and raises a sticky overflow flag. While the enable input is low, no new events are captured. The timestamp counter can be cleared synchronously.

Top module: `edge_stamp_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `ev_valid` and `ovf` to 0 and sets the timestamp counter to 0, so that the counter value directly after the last reset edge is 0.
- R2: A new level on a channel input that is first sampled at clock edge K and held for at least 4 cycles produces an event word, with `ev_valid` high directly after edge K+6. A level held for 3 cycles or fewer produces no word.
- R3: Both directions produce a word. Bit 1 of `ev_data` is 1 for a rising change and 0 for a falling change.
- R4: Word layout: bits [63:8] hold the timestamp, bits [7:6] hold the channel number in binary (0 to 3), and bits [5:2] and bit 0 are 0.
- R5: The timestamp counter adds 1 every clock and wraps. `ts_clr` sampled high at edge P makes it 0 directly after P. A change first sampled at edge K (as in R2) carries timestamp K-P+5.
- R6: Changes on several channels in the same cycle give one word per channel, all with the same timestamp. With `ev_ready` high, these words leave in consecutive cycles in ascending channel order. When a word is first offered, it is the one of the lowest-numbered channel that has a pending word.
- R7: A word is transferred at a clock edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_data` stays unchanged.
- R8: Each channel holds at most one pending word. A new event on a channel whose word is still pending, and not transferred at that same edge, is dropped and sets `ovf`. `ovf` stays high until reset.
- R9: While `en` is low, filtered changes produce no words. The filters keep tracking the inputs, so a change completed while disabled gives no word when `en` returns high, and the next change after that is reported normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 125 MHz |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable |
| ts_clr | input | 1 | Synchronous timestamp counter clear |
| din | input | 4 | Asynchronous channel inputs, bit n is channel n |
| ev_valid | output | 1 | Event word available |
| ev_ready | input | 1 | Downstream accepts the word at this edge |
| ev_data | output | 64 | Event word |
| ovf | output | 1 | Sticky overflow: an event was dropped |

## Verification
The latency from an input change to its word is fixed. The change is first sampled at edge K: the synchroniser adds two edges, the filter's fourth agreeing sample falls on edge K+5, and the pending slot loads on K+6. The bench therefore records each offered word together with its own edge count and expects exactly K+6 as that count and K-P+5 as the stamp. Bench inputs change on falling edges, and the outputs are read just after a falling edge, so every comparison sees settled values half a period away from the capturing edge. Filter rejection, disabled capture and the overflow drop are each judged by the number of words observed over a window longer than the full pipeline.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    localparam int WORD_W = 64;
    localparam int CH_W   = 2;
    localparam int RSV_W  = 4;
    localparam int TS_W   = WORD_W - CH_W - RSV_W - 2;

    typedef logic [TS_W-1:0] stamp_t;

    // Outgoing event word, most significant field first
    typedef struct packed {
        stamp_t            ts;
        logic [CH_W-1:0]   ch;
        logic [RSV_W-1:0]  rsv;
        logic              rise;
        logic              pad;
    } ev_word_t;

    // One pending event per channel
    typedef struct packed {
        logic   vld;
        logic   rise;
        stamp_t ts;
    } slot_t;

    function automatic ev_word_t pack_word(input stamp_t ts,
                                           input logic [CH_W-1:0] ch,
                                           input logic rise);
        ev_word_t w;
        w.ts   = ts;
        w.ch   = ch;
        w.rsv  = '0;
        w.rise = rise;
        w.pad  = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end

endmodule

// File: rtl/glitch_filt.sv
module glitch_filt #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic chg
);

    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
            chg   <= 1'b0;
        end else begin
            chg <= 1'b0;
            if (raw == level) begin
                cnt <= '0;
            end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
                level <= raw;
                cnt   <= '0;
                chg   <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/event_slots.sv
module event_slots
    import stamp_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [N_CH-1:0]   chg,
    input  logic [N_CH-1:0]   lvl,
    input  stamp_t            ts,
    input  logic              ev_ready,
    output logic              ev_valid,
    output logic [WORD_W-1:0] ev_data,
    output logic              ovf
);

    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    slot_t            slots [N_CH];
    logic [SEL_W-1:0] pick;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] sel_q;
    logic             any;
    logic             stall_q;
    logic [N_CH-1:0]  pop;

    // Lowest occupied slot wins; a stalled offer keeps its channel
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (slots[i].vld) begin
                any  = 1'b1;
                pick = SEL_W'(i);
            end
        end
        sel = stall_q ? sel_q : pick;
    end

    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            pop[i] = any && ev_ready && (sel == SEL_W'(i));
        end
    end

    assign ev_valid = any;
    assign ev_data  = pack_word(slots[sel].ts, CH_W'(sel), slots[sel].rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= 1'b0;
            sel_q   <= '0;
            ovf     <= 1'b0;
            for (int i = 0; i < N_CH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            stall_q <= any && !ev_ready;
            sel_q   <= sel;
            for (int i = 0; i < N_CH; i++) begin
                if (en && chg[i]) begin
                    if (slots[i].vld && !pop[i]) begin
                        ovf <= 1'b1;
                    end else begin
                        slots[i] <= '{vld: 1'b1, rise: lvl[i], ts: ts};
                    end
                end else if (pop[i]) begin
                    slots[i].vld <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
    import stamp_pkg::*;
#(
    parameter int N_CH     = 4,
    parameter int FILT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ts_clr,
    input  logic [N_CH-1:0]   din,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [WORD_W-1:0] ev_data,
    output logic              ovf
);

    logic [N_CH-1:0] din_s;
    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] chg;
    stamp_t          ts;

    always_ff @(posedge clk) begin
        if (rst || ts_clr) begin
            ts <= '0;
        end else begin
            ts <= ts + 1'b1;
        end
    end

    edge_sync #(.W(N_CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (din),
        .d_sync  (din_s)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_filt
        glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (din_s[c]),
            .level (lvl[c]),
            .chg   (chg[c])
        );
    end

    event_slots #(.N_CH(N_CH)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .chg      (chg),
        .lvl      (lvl),
        .ts       (ts),
        .ev_ready (ev_ready),
        .ev_valid (ev_valid),
        .ev_data  (ev_data),
        .ovf      (ovf)
    );

endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        ev_valid,
    input logic        ev_ready,
    input logic [63:0] ev_data,
    input logic        ovf
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !ev_valid && !ovf);

    a_r7_hold_offer: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_data));

    a_r4_zero_fields: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_data[5:2] == 4'b0) && !ev_data[0]);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r9_idle_disabled: assert property (@(posedge clk) disable iff (rst)
        !ev_valid && !en |=> !ev_valid);

endmodule

bind edge_stamp_unit edge_stamp_chk u_chk (.*);

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;

    localparam int CLK_PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        ts_clr = 1'b0;
    logic [3:0]  din = 4'b0;
    logic        ev_ready = 1'b1;
    logic        ev_valid;
    logic [63:0] ev_data;
    logic        ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int mcount = 0;
    logic [63:0] mdata [64];
    int          mcyc  [64];
    int          p_edge;
    int          k_edge;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edge_stamp_unit u_edge_stamp_unit (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ts_clr   (ts_clr),
        .din      (din),
        .ev_valid (ev_valid),
        .ev_ready (ev_ready),
        .ev_data  (ev_data),
        .ovf      (ovf)
    );

    // Record every word that will transfer at the next rising edge
    always @(negedge clk) begin
        #1;
        if (!rst && ev_valid && ev_ready && mcount < 64) begin
            mdata[mcount] = ev_data;
            mcyc[mcount]  = cyc;
            mcount++;
        end
    end

    function automatic logic [63:0] word(input int ts, input int ch, input bit r);
        return {56'(ts), 2'(ch), 4'b0, r, 1'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample_point();
        @(negedge clk);
        #2;
    endtask

    task automatic clear_ts();
        @(negedge clk);
        ts_clr = 1'b1;
        p_edge = cyc + 1;
        @(negedge clk);
        ts_clr = 1'b0;
    endtask

    task automatic set_pin(input int ch, input bit v);
        @(negedge clk);
        din[ch] = v;
        k_edge = cyc + 1;
    endtask

    task automatic t_reset();
        int kr;
        ticks(4);
        @(negedge clk);
        rst = 1'b0;
        p_edge = cyc;
        #2;
        check("R1 valid after reset", 64'(ev_valid), 64'd0);
        check("R1 ovf after reset", 64'(ovf), 64'd0);
        mcount = 0;
        set_pin(0, 1'b1);
        kr = k_edge;
        ticks(8);
        set_pin(0, 1'b0);
        ticks(12);
        check("R1 count", 64'(mcount), 64'd2);
        check("R1 stamp from reset", mdata[0], word(kr - p_edge + 5, 0, 1'b1));
    endtask

    task automatic t_single();
        int k1, k2;
        clear_ts();
        mcount = 0;
        set_pin(1, 1'b1);
        k1 = k_edge;
        ticks(8);
        set_pin(1, 1'b0);
        k2 = k_edge;
        ticks(12);
        check("R2 single count", 64'(mcount), 64'd2);
        check("R3 R4 R5 rising word", mdata[0], word(k1 - p_edge + 5, 1, 1'b1));
        check("R2 rising latency", 64'(mcyc[0]), 64'(k1 + 6));
        check("R3 R5 falling word", mdata[1], word(k2 - p_edge + 5, 1, 1'b0));
        check("R2 falling latency", 64'(mcyc[1]), 64'(k2 + 6));
    endtask

    task automatic t_glitch();
        mcount = 0;
        set_pin(2, 1'b1);
        ticks(3);
        din[2] = 1'b0;
        ticks(14);
        check("R2 three-cycle pulse dropped", 64'(mcount), 64'd0);
        set_pin(2, 1'b1);
        ticks(4);
        din[2] = 1'b0;
        ticks(16);
        check("R2 four-cycle pulse kept", 64'(mcount), 64'd2);
        check("R3 pulse order", {62'd0, mdata[0][1], mdata[1][1]}, 64'd2);
    endtask

    task automatic t_simul();
        int k1;
        clear_ts();
        mcount = 0;
        @(negedge clk);
        din = 4'b1101;
        k1 = cyc + 1;
        ticks(14);
        check("R6 count", 64'(mcount), 64'd3);
        check("R6 first ch0", mdata[0], word(k1 - p_edge + 5, 0, 1'b1));
        check("R6 second ch2", mdata[1], word(k1 - p_edge + 5, 2, 1'b1));
        check("R6 third ch3", mdata[2], word(k1 - p_edge + 5, 3, 1'b1));
        check("R6 back to back", 64'(mcyc[2] - mcyc[0]), 64'd2);
        @(negedge clk);
        din = 4'b0000;
        ticks(16);
        check("R6 falling count", 64'(mcount), 64'd6);
    endtask

    task automatic t_stall();
        int k1;
        clear_ts();
        mcount = 0;
        @(negedge clk);
        ev_ready = 1'b0;
        set_pin(1, 1'b1);
        k1 = k_edge;
        ticks(8);
        sample_point();
        check("R7 offered while stalled", 64'(ev_valid), 64'd1);
        check("R7 stalled word", ev_data, word(k1 - p_edge + 5, 1, 1'b1));
        ticks(4);
        sample_point();
        check("R7 word held", ev_data, word(k1 - p_edge + 5, 1, 1'b1));
        @(negedge clk);
        ev_ready = 1'b1;
        sample_point();
        check("R7 one transfer", 64'(mcount), 64'd1);
        check("R7 valid drops", 64'(ev_valid), 64'd0);
        set_pin(1, 1'b0);
        ticks(12);
    endtask

    task automatic t_disable();
        mcount = 0;
        @(negedge clk);
        en = 1'b0;
        set_pin(3, 1'b1);
        ticks(14);
        @(negedge clk);
        en = 1'b1;
        ticks(14);
        check("R9 nothing while disabled", 64'(mcount), 64'd0);
        set_pin(3, 1'b0);
        ticks(14);
        check("R9 next change count", 64'(mcount), 64'd1);
        check("R9 next change falling ch3", {62'd0, mdata[0][7:6]} | {63'd0, mdata[0][1]}, 64'd3);
    endtask

    task automatic t_overflow();
        mcount = 0;
        @(negedge clk);
        ev_ready = 1'b0;
        set_pin(0, 1'b1);
        ticks(8);
        set_pin(0, 1'b0);
        ticks(14);
        sample_point();
        check("R8 ovf set", 64'(ovf), 64'd1);
        @(negedge clk);
        ev_ready = 1'b1;
        ticks(4);
        check("R8 one word left", 64'(mcount), 64'd1);
        check("R8 kept word is rising ch0", {62'd0, mdata[0][7:6]} | {63'd0, mdata[0][1]}, 64'd1);
        ticks(6);
        sample_point();
        check("R8 ovf sticky", 64'(ovf), 64'd1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_glitch();
        t_simul();
        t_stall();
        t_disable();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule